// File: doc/BRIEF.md
# Quadrature Position Counter

This block turns the two signals of an incremental rotary encoder into a position count. It follows each phase through a two-stage synchronizer, an optional per-phase inversion and an optional per-phase glitch filter. A step decoder then turns the conditioned phases into up/down steps. A modulo counter applies the steps and wraps between a programmable low limit and a programmable high limit.

Two input encodings are supported. In two-phase quadrature mode every clean edge on either phase moves the count by one, and the order of the phases gives the direction. In count-plus-direction mode the first phase carries count pulses and the second phase gives the direction as a level. Control and status are plain level pins. The phase inputs are sampled levels with no handshake, so there is no back-pressure: a step cannot be refused or held.

A wrap raises a one-cycle wrap pulse and records whether it happened at the top or at the bottom of the range. A clear input reloads the count with the low limit.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset, `count_o` is 0, `dir_up_o` is 1, and `wrap_o` and `wrap_top_o` are 0.
- R2: With `mode_i`=0 (quadrature), each edge of either conditioned phase moves the count by one. Taking the (A,B) pair through 00, 10, 11, 01, 00 counts up; taking it through the reverse order counts down. `dir_up_o` shows the direction of the most recent step.
- R3: With `mode_i`=0, if both conditioned phases change in the same clock cycle, the change is treated as invalid and the count does not move.
- R4: With `mode_i`=1 (count plus direction), only a rising edge of conditioned phase A moves the count. It counts up when conditioned phase B is 1 and down when it is 0. Falling A edges and any change of B leave the count unchanged.
- R5: When `inv_a_i` or `inv_b_i` is 1, the matching phase is inverted after synchronization and before filtering and decoding. With A inverted in count-plus-direction mode, a falling edge on the A pin counts.
- R6: When a phase's filter value N is nonzero, a new level on that phase reaches the decoder only after it has held for N consecutive clocks. A level that holds for fewer than N clocks is dropped. N=0 bypasses the filter.
- R7: An up step taken when the count is at or above `lim_hi_i` loads `lim_lo_i`. In the same cycle it pulses `wrap_o` for one cycle and sets `wrap_top_o` to 1. `wrap_top_o` changes only when a wrap occurs.
- R8: A down step taken when the count is at or below `lim_lo_i` loads `lim_hi_i`. In the same cycle it pulses `wrap_o` for one cycle and sets `wrap_top_o` to 0.
- R9: A cycle with `clear_i`=1 loads `lim_lo_i` into the count on the next edge without pulsing `wrap_o`. Clear takes priority over a step arriving in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: quadrature, 1: count plus direction |
| phase_a_i | input | 1 | Encoder phase A pin (asynchronous) |
| phase_b_i | input | 1 | Encoder phase B pin (asynchronous) |
| inv_a_i | input | 1 | Invert phase A |
| inv_b_i | input | 1 | Invert phase B |
| filt_a_i | input | FILT_W | Phase A filter length in clocks, 0 = off |
| filt_b_i | input | FILT_W | Phase B filter length in clocks, 0 = off |
| lim_lo_i | input | CNT_W | Low wrap limit and clear value |
| lim_hi_i | input | CNT_W | High wrap limit |
| clear_i | input | 1 | Load the low limit into the count |
| count_o | output | CNT_W | Position count |
| dir_up_o | output | 1 | 1 if the last step counted up |
| wrap_o | output | 1 | One-cycle pulse when the count wraps |
| wrap_top_o | output | 1 | 1 if the last wrap was at the high limit |

## Verification
The bench tests the ends of the range from both sides. A counter that compares against the wrong limit, or sets the top/bottom bit backwards, would land on the wrong value or report the wrong wrap location. It drives a simultaneous change of both phases, which a naive decoder would turn into a spurious step in either direction. It sends a glitch shorter than the filter length, which a filter that counts total time instead of stable time would let through, and it checks that a long filtered edge is not visible early. In count-plus-direction mode it sends falling A edges and B changes that must not count. It also inverts phase A, which must turn a falling pin edge into a counted one.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic {
    ENC_QUAD   = 1'b0,
    ENC_CNTDIR = 1'b1
  } enc_mode_e;

  localparam int NUM_PHASES = 2;
  localparam int PH_A = 0;
  localparam int PH_B = 1;
endpackage

// File: rtl/qpc_phase_cond.sv
// One encoder phase: two-flop synchronizer, polarity select, stability filter.
module qpc_phase_cond #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              inv_i,
  input  logic [FILT_W-1:0] filt_i,
  output logic              lvl_o
);
  localparam logic [FILT_W:0] RUN_ONE = {{FILT_W{1'b0}}, 1'b1};

  logic              sync1_q, sync2_q;
  logic              held_q;
  logic [FILT_W-1:0] run_q;
  logic              cond;
  logic              bypass;

  assign cond   = sync2_q ^ inv_i;
  assign bypass = (filt_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      held_q  <= 1'b0;
      run_q   <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      if (bypass) begin
        held_q <= cond;
        run_q  <= '0;
      end else if (cond == held_q) begin
        run_q <= '0;
      end else if (({1'b0, run_q} + RUN_ONE) >= {1'b0, filt_i}) begin
        held_q <= cond;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign lvl_o = bypass ? cond : held_q;
endmodule

// File: rtl/qpc_step_decode.sv
// Turns conditioned phase levels into up/down steps for the selected encoding.
module qpc_step_decode
  import qpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  input  logic a_i,
  input  logic b_i,
  output logic step_o,
  output logic up_o
);
  logic      a_prev_q, b_prev_q;
  logic      a_chg, b_chg;
  enc_mode_e mode;

  assign mode  = enc_mode_e'(mode_i);
  assign a_chg = a_i ^ a_prev_q;
  assign b_chg = b_i ^ b_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      a_prev_q <= a_i;
      b_prev_q <= b_i;
    end
  end

  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b0;
    unique case (mode)
      ENC_QUAD: begin
        // exactly one phase moved; both moving is an illegal jump
        step_o = a_chg ^ b_chg;
        up_o   = a_chg ? (a_i != b_i) : (a_i == b_i);
      end
      ENC_CNTDIR: begin
        step_o = a_i & ~a_prev_q;
        up_o   = b_i;
      end
      default: begin
        step_o = 1'b0;
        up_o   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/qpc_mod_counter.sv
// Position counter wrapping between two programmable limits.
module qpc_mod_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_up_o,
  output logic             wrap_o,
  output logic             wrap_top_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o    <= '0;
      dir_up_o   <= 1'b1;
      wrap_o     <= 1'b0;
      wrap_top_o <= 1'b0;
    end else begin
      wrap_o <= 1'b0;
      if (clear_i) begin
        count_o <= lo_i;
      end else if (step_i) begin
        dir_up_o <= up_i;
        if (up_i) begin
          if (count_o >= hi_i) begin
            count_o    <= lo_i;
            wrap_o     <= 1'b1;
            wrap_top_o <= 1'b1;
          end else begin
            count_o <= count_o + 1'b1;
          end
        end else begin
          if (count_o <= lo_i) begin
            count_o    <= hi_i;
            wrap_o     <= 1'b1;
            wrap_top_o <= 1'b0;
          end else begin
            count_o <= count_o - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic              phase_a_i,
  input  logic              phase_b_i,
  input  logic              inv_a_i,
  input  logic              inv_b_i,
  input  logic [FILT_W-1:0] filt_a_i,
  input  logic [FILT_W-1:0] filt_b_i,
  input  logic [CNT_W-1:0]  lim_lo_i,
  input  logic [CNT_W-1:0]  lim_hi_i,
  input  logic              clear_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              dir_up_o,
  output logic              wrap_o,
  output logic              wrap_top_o
);
  logic [NUM_PHASES-1:0] pin_v, inv_v, lvl_v;
  logic [FILT_W-1:0]     filt_v [NUM_PHASES];
  logic                  step, step_up;

  assign pin_v[PH_A]  = phase_a_i;
  assign pin_v[PH_B]  = phase_b_i;
  assign inv_v[PH_A]  = inv_a_i;
  assign inv_v[PH_B]  = inv_b_i;
  assign filt_v[PH_A] = filt_a_i;
  assign filt_v[PH_B] = filt_b_i;

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
    qpc_phase_cond #(.FILT_W(FILT_W)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_v[g]),
      .inv_i  (inv_v[g]),
      .filt_i (filt_v[g]),
      .lvl_o  (lvl_v[g])
    );
  end

  qpc_step_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .a_i    (lvl_v[PH_A]),
    .b_i    (lvl_v[PH_B]),
    .step_o (step),
    .up_o   (step_up)
  );

  qpc_mod_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (step),
    .up_i       (step_up),
    .clear_i    (clear_i),
    .lo_i       (lim_lo_i),
    .hi_i       (lim_hi_i),
    .count_o    (count_o),
    .dir_up_o   (dir_up_o),
    .wrap_o     (wrap_o),
    .wrap_top_o (wrap_top_o)
  );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic [CNT_W-1:0] lim_lo_i,
  input logic [CNT_W-1:0] lim_hi_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_up_o,
  input logic             wrap_o,
  input logic             wrap_top_o
);
  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clear_i) && !wrap_o && (count_o != $past(count_o))) |->
      (((count_o == $past(count_o) + 1'b1) && dir_up_o) ||
       ((count_o == $past(count_o) - 1'b1) && !dir_up_o)));

  assert_top_wrap_lands_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && wrap_top_o) |-> (count_o == $past(lim_lo_i)));

  assert_wrap_top_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_o |-> (wrap_top_o == $past(wrap_top_o)));

  assert_bottom_wrap_lands_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_o && !wrap_top_o) |-> (count_o == $past(lim_hi_i)));

  assert_clear_loads_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_i) |-> ((count_o == $past(lim_lo_i)) && !wrap_o));
endmodule

bind quad_pos_counter qpc_checker #(.CNT_W(CNT_W)) u_qpc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .clear_i    (clear_i),
  .lim_lo_i   (lim_lo_i),
  .lim_hi_i   (lim_hi_i),
  .count_o    (count_o),
  .dir_up_o   (dir_up_o),
  .wrap_o     (wrap_o),
  .wrap_top_o (wrap_top_o)
);

// File: tb/tb_quad_pos_counter.sv
module tb_quad_pos_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int FW = 4;
  localparam int SETTLE = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode = 1'b0;
  logic          pa = 1'b0, pb = 1'b0;
  logic          inv_a = 1'b0, inv_b = 1'b0;
  logic [FW-1:0] filt_a = '0, filt_b = '0;
  logic [CW-1:0] lo = 16'd5, hi = 16'd9;
  logic          clr = 1'b0;
  logic [CW-1:0] count_o;
  logic          dir_up_o, wrap_o, wrap_top_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_pos_counter #(.CNT_W(CW), .FILT_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .phase_a_i(pa), .phase_b_i(pb), .inv_a_i(inv_a), .inv_b_i(inv_b),
    .filt_a_i(filt_a), .filt_b_i(filt_b), .lim_lo_i(lo), .lim_hi_i(hi),
    .clear_i(clr), .count_o(count_o), .dir_up_o(dir_up_o),
    .wrap_o(wrap_o), .wrap_top_o(wrap_top_o)
  );

  typedef struct {
    logic [CW-1:0] cnt;
    logic          up;
    logic          wrap;
    logic          top;
    string         req;
  } exp_t;

  exp_t          exp_q[$];
  int            n_chk = 0, n_bad = 0;
  logic [CW-1:0] m_cnt = '0;
  logic          m_up = 1'b1, m_top = 1'b0;
  logic [CW-1:0] last_cnt = '0;
  bit            mon_on = 0;
  bit            done = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(logic w, string req);
    exp_t e;
    e.cnt = m_cnt; e.up = m_up; e.wrap = w; e.top = m_top; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic model_step(bit up, string req);
    logic w;
    w = 1'b0;
    m_up = up;
    if (up) begin
      if (m_cnt >= hi) begin m_cnt = lo; w = 1'b1; m_top = 1'b1; end
      else m_cnt = m_cnt + 1'b1;
    end else begin
      if (m_cnt <= lo) begin m_cnt = hi; w = 1'b1; m_top = 1'b0; end
      else m_cnt = m_cnt - 1'b1;
    end
    push(w, req);
  endtask

  task automatic drive(logic a, logic b);
    @(negedge clk);
    pa = a; pb = b;
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic do_clear(string req);
    if (m_cnt != lo) begin m_cnt = lo; push(1'b0, req); end
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    repeat (SETTLE) @(negedge clk);
  endtask

  // monitor: every visible count change must match the next expected item
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (count_o != last_cnt) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected count change: actual %0d expected %0d", count_o, last_cnt);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (count_o !== e.cnt || dir_up_o !== e.up || wrap_o !== e.wrap || wrap_top_o !== e.top) begin
            n_bad++;
            $display("FAIL %s: actual cnt=%0d up=%0d wrap=%0d top=%0d expected cnt=%0d up=%0d wrap=%0d top=%0d",
                     e.req, count_o, dir_up_o, wrap_o, wrap_top_o, e.cnt, e.up, e.wrap, e.top);
          end
        end
        last_cnt = count_o;
      end else if (wrap_o) begin
        n_chk++; n_bad++;
        $display("FAIL wrap pulse without count change: actual 1 expected 0");
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "count", count_o, 0);
    check("R1", "dir_up", dir_up_o, 1);
    check("R1", "wrap", wrap_o, 0);
    check("R1", "wrap_top", wrap_top_o, 0);
    last_cnt = count_o;
    mon_on = 1;

    do_clear("R9");                         // 0 -> 5
    // R2 quadrature forward, then R7 top wrap
    model_step(1, "R2"); drive(1, 0);       // 6
    model_step(1, "R2"); drive(1, 1);       // 7
    model_step(1, "R2"); drive(0, 1);       // 8
    model_step(1, "R2"); drive(0, 0);       // 9
    model_step(1, "R7"); drive(1, 0);       // wrap -> 5, top
    // R8 bottom wrap on reverse, then R2 reverse
    model_step(0, "R8"); drive(0, 0);       // wrap -> 9, bottom
    model_step(0, "R2"); drive(0, 1);       // 8
    model_step(0, "R2"); drive(1, 1);       // 7
    // R3 both phases together: ignored
    drive(0, 0);
    check("R3", "count after double change", count_o, 7);

    // R6 glitch shorter than filter is dropped
    @(negedge clk); filt_a = 4'd5;
    @(negedge clk); pa = 1'b1;
    repeat (3) @(negedge clk); pa = 1'b0;
    repeat (SETTLE) @(negedge clk);
    check("R6", "count after short glitch", count_o, 7);
    // R6 stable edge passes, but only after the filter time
    model_step(1, "R6");
    @(negedge clk); pa = 1'b1;
    repeat (6) @(negedge clk);
    check("R6", "count before filter time", count_o, 7);
    repeat (SETTLE) @(negedge clk);
    check("R6", "count after filter time", count_o, 8);
    @(negedge clk); filt_a = '0;

    // R4 count plus direction
    @(negedge clk); mode = 1'b1;
    drive(1, 1);                            // B change only
    drive(0, 1);                            // falling A
    check("R4", "count after B change and falling A", count_o, 8);
    model_step(1, "R4"); drive(1, 1);       // rising A, up -> 9
    drive(0, 1);
    drive(0, 0);
    model_step(0, "R4"); drive(1, 0);       // rising A, down -> 8
    check("R4", "dir_up after down count", dir_up_o, 0);

    // R5 inversion of A: pin falling edge counts
    @(negedge clk); inv_a = 1'b1;           // conditioned A falls: no count
    repeat (SETTLE) @(negedge clk);
    check("R5", "count after inverting A", count_o, 8);
    model_step(0, "R5"); drive(0, 0);       // pin falls, conditioned rises -> 7
    check("R5", "count after inverted edge", count_o, 7);

    // R9 with a new low limit, then R8 wrap to high limit from it
    @(negedge clk); lo = 16'd2;
    do_clear("R9");                         // -> 2
    check("R9", "count after clear", count_o, 2);
    drive(1, 0);                            // conditioned A falls: no count
    model_step(0, "R8"); drive(0, 0);       // 2 <= lo -> 9
    check("R8", "wrap_top after bottom wrap", wrap_top_o, 0);

    repeat (SETTLE) @(negedge clk);
    check("R2", "scoreboard items left", exp_q.size(), 0);
    finish_run();
  end
endmodule